// File: doc/BRIEF.md
# Interrupt-to-Transfer Activation Router

This block sits between a bank of peripheral request flags and two consumers: the CPU interrupt logic and a data-transfer engine. Each source has its own routing bit. When the bit is clear, the source's flag appears on the matching CPU interrupt line. When the bit is set, the flag instead claims the transfer engine. Software can also claim the engine by writing a descriptor number together with an enable bit into a vector register.

The router keeps only one activation in flight. It issues a one-cycle start strobe, which carries the descriptor number and a software/hardware marker, and then waits for the engine's done strobe.

With the final done of a chain, the engine reports two things: whether the descriptor asks for a CPU interrupt, and whether its transfer count has run out. From these the router decides the end-of-transfer action:
- clear the peripheral flag through a one-cycle clear pulse, or
- drop the source's routing bit, so that the still-set flag reaches the CPU.

Software activations get the matching treatment. Either the software enable bit is cleared, or a dedicated software-end interrupt is raised and held.

Top module: `dma_act_router`

## Requirements
- R1: `cpuIrq[i]` equals `srcFlag[i]` AND NOT `enState[i]` at all times, so a flag whose routing bit is 0 reaches the CPU and never starts a transfer.
- R2: A pending source with its routing bit at 1 produces a `xferStart` pulse exactly one cycle wide, with `xferVec` equal to the source index and `xferSw` = 0. No further start is issued until a done with `xferDoneLast` = 1 has been received.
- R3: When several routed sources are pending, the lowest index is started first. A pending software request is started only when no routed hardware source is pending.
- R4: Writing the vector register with `swWrEn` = 1 sets `swEnState` and produces a start with `xferVec` equal to the written number and `xferSw` = 1.
- R5: A final done for a hardware activation with `xferDoneSel` = 0 and `xferDoneCntEnd` = 0 produces, in the next cycle, a single-cycle `srcClr` pulse on that source's bit only. The routing bit stays 1 and no CPU interrupt results.
- R6: A final done for a hardware activation with `xferDoneSel` = 1 or `xferDoneCntEnd` = 1 clears that source's routing bit. No `srcClr` pulse is produced, so the still-set flag appears on `cpuIrq`.
- R7: A final done for a software activation with `xferDoneSel` = 0 and `xferDoneCntEnd` = 0 clears `swEnState`, and `swEndIrq` stays 0.
- R8: A final done for a software activation with `xferDoneSel` = 1 or `xferDoneCntEnd` = 1 leaves `swEnState` at 1 and raises `swEndIrq`. `swEndIrq` holds, and no new software start is issued, until the vector register is written with `swWrEn` = 0.
- R9: A done with `xferDoneLast` = 0 (a chain link) changes no routing bit, flag or software bit and issues no new start.
- R10: After reset all routing bits, `swEnState`, `swEndIrq`, `xferStart` and `srcClr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcFlag | input | NUM_SRC | Peripheral request flags (levels) |
| srcClr | output | NUM_SRC | One-cycle clear pulse for a peripheral flag |
| cpuIrq | output | NUM_SRC | Per-source CPU interrupt requests |
| enWe | input | 1 | Write strobe for the routing-bit register |
| enWdata | input | NUM_SRC | Data for the routing-bit register |
| enState | output | NUM_SRC | Current routing bits |
| swWe | input | 1 | Write strobe for the software vector register |
| swWrVec | input | VEC_W | Descriptor number for software activation |
| swWrEn | input | 1 | Software enable bit written with the vector |
| swEnState | output | 1 | Current software enable bit |
| swEndIrq | output | 1 | Software-transfer-end CPU interrupt |
| xferStart | output | 1 | One-cycle start strobe to the transfer engine |
| xferVec | output | VEC_W | Descriptor number of the started activation |
| xferSw | output | 1 | 1 when the started activation came from software |
| xferDone | input | 1 | Done strobe from the engine |
| xferDoneLast | input | 1 | Done is for the last link of a chain |
| xferDoneSel | input | 1 | Descriptor's interrupt-select bit |
| xferDoneCntEnd | input | 1 | Transfer count has run out |

## Verification
The hardest case to reach is a routed hardware source and a software request becoming pending in the same cycle. The arbitration must then take the hardware source first and start the software request only after the clear pulse has removed the hardware flag. The bench gets there by setting the routing bit ahead of time, then asserting the flag-set stimulus and the vector-register write on one falling edge. It then follows two complete start/done rounds. A second case that is hard to reach is a mid-chain done. The bench returns a done without the last-link marker and watches for several cycles that nothing is cleared and nothing is restarted.

// File: rtl/dma_act_router_pkg.sv
package dma_act_router_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // latch the winning request and begin a transfer
    logic finish;   // apply end-of-transfer rules for the in-flight activation
  } rtrStb_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_SETTLE = 2'd2
  } rtrState_t;

endpackage

// File: rtl/dma_act_arb.sv
module dma_act_arb #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pend,
  output logic               anyReq,
  output logic [SRC_W-1:0]   grantIdx
);

  logic [NUM_SRC-1:0] grantOh;

  // One-hot winner: a bit wins when no lower-numbered bit is pending
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_win
      if (gi == 0) begin : g_first
        assign grantOh[gi] = pend[gi];
      end else begin : g_rest
        assign grantOh[gi] = pend[gi] & ~(|pend[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grantOh[i]) grantIdx = grantIdx | SRC_W'(i);
    end
  end

  assign anyReq = |pend;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh)) else $error("grant not one-hot"); // R3
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> pend[grantIdx]) else $error("grant to idle source"); // R3
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> ((pend & ((NUM_SRC'(1) << grantIdx) - NUM_SRC'(1))) == '0))
    else $error("lower source skipped"); // R3

endmodule

// File: rtl/dma_act_ctrl.sv
module dma_act_ctrl
  import dma_act_router_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqAny,
  input  logic    xferDone,
  input  logic    xferDoneLast,
  output rtrStb_t stb,
  output logic    xferStart
);

  rtrState_t state, stateNext;
  logic      startReg;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqAny) begin
          stb.capture = 1'b1;
          stateNext   = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (xferDone && xferDoneLast) begin
          stb.finish = 1'b1;
          stateNext  = ST_SETTLE;
        end
      end
      ST_SETTLE: stateNext = ST_IDLE;  // lets the cleared flag fall before re-arbitration
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      startReg <= 1'b0;
    end else begin
      state    <= stateNext;
      startReg <= stb.capture;
    end
  end

  assign xferStart = startReg;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart) else $error("start wider than one cycle"); // R2
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> (state == ST_BUSY)) else $error("start outside busy"); // R2
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && xferDone && !xferDoneLast) |=> (state == ST_BUSY && !xferStart))
    else $error("chain link ended activation"); // R9

endmodule

// File: rtl/dma_act_dp.sv
module dma_act_dp
  import dma_act_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 6,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic               enWe,
  input  logic [NUM_SRC-1:0] enWdata,
  input  logic               swWe,
  input  logic [VEC_W-1:0]   swWrVec,
  input  logic               swWrEn,
  input  logic               xferDoneSel,
  input  logic               xferDoneCntEnd,
  input  rtrStb_t            stb,
  output logic               reqAny,
  output logic [NUM_SRC-1:0] srcClr,
  output logic [NUM_SRC-1:0] cpuIrq,
  output logic               swEndIrq,
  output logic [NUM_SRC-1:0] enState,
  output logic               swEnState,
  output logic [VEC_W-1:0]   xferVec,
  output logic               xferSw
);

  logic [NUM_SRC-1:0] enReg, enNext;
  logic [NUM_SRC-1:0] clrReg, clrNext;
  logic               swEnReg, swEnNext;
  logic               swHoldReg, swHoldNext;
  logic [VEC_W-1:0]   swVecReg;
  logic [VEC_W-1:0]   curIdx;
  logic               curSw;
  logic               hwAny;
  logic [SRC_W-1:0]   hwIdx;
  logic [SRC_W-1:0]   curHwIdx;
  logic               swPend;
  logic               finIntr;

  dma_act_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) arb_i (
    .clk      (clk),
    .rstN     (rstN),
    .pend     (srcFlag & enReg),
    .anyReq   (hwAny),
    .grantIdx (hwIdx)
  );

  assign swPend   = swEnReg & ~swHoldReg;
  assign reqAny   = hwAny | swPend;
  assign finIntr  = xferDoneSel | xferDoneCntEnd;
  assign curHwIdx = curIdx[SRC_W-1:0];

  // Routing bits: CPU write first, completion clear has the last word
  always_comb begin
    enNext = enWe ? enWdata : enReg;
    if (stb.finish && !curSw && finIntr) enNext[curHwIdx] = 1'b0;
  end

  // Flag clear pulse for an ordinary hardware completion
  always_comb begin
    clrNext = '0;
    if (stb.finish && !curSw && !finIntr) clrNext[curHwIdx] = 1'b1;
  end

  // Software enable and end-interrupt hold
  always_comb begin
    swEnNext   = swEnReg;
    swHoldNext = swHoldReg;
    if (swWe) begin
      swEnNext   = swWrEn;
      swHoldNext = 1'b0;
    end
    if (stb.finish && curSw) begin
      if (finIntr) swHoldNext = 1'b1;
      else         swEnNext   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= '0;
      clrReg    <= '0;
      swEnReg   <= 1'b0;
      swHoldReg <= 1'b0;
      swVecReg  <= '0;
      curIdx    <= '0;
      curSw     <= 1'b0;
    end else begin
      enReg     <= enNext;
      clrReg    <= clrNext;
      swEnReg   <= swEnNext;
      swHoldReg <= swHoldNext;
      if (swWe) swVecReg <= swWrVec;
      if (stb.capture) begin
        curSw  <= ~hwAny;
        curIdx <= hwAny ? VEC_W'(hwIdx) : swVecReg;
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_irq
      assign cpuIrq[gi] = srcFlag[gi] & ~enReg[gi];
    end
  endgenerate

  assign srcClr    = clrReg;
  assign swEndIrq  = swEnReg & swHoldReg;
  assign enState   = enReg;
  assign swEnState = swEnReg;
  assign xferVec   = curIdx;
  assign xferSw    = curSw;

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcClr)) else $error("several flags cleared"); // R5
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|srcClr) |=> (srcClr == '0)) else $error("clear wider than one cycle"); // R5
  AST_HW_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !curSw && finIntr) |=> (enReg[$past(curHwIdx)] == 1'b0 && srcClr == '0))
    else $error("routing bit kept after interrupting end"); // R6
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && curSw && !finIntr && !swWe) |=> (!swEnState && !swEndIrq))
    else $error("software enable kept"); // R7
  AST_SW_END_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (swEndIrq && !swWe) |=> swEndIrq) else $error("software end irq dropped"); // R8

endmodule

// File: rtl/dma_act_router.sv
module dma_act_router
  import dma_act_router_pkg::*;
#(
  parameter int NUM_SRC = 8,   // 2..64 sources
  parameter int VEC_W   = 6    // descriptor number width, at least clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcFlag,
  output logic [NUM_SRC-1:0] srcClr,
  output logic [NUM_SRC-1:0] cpuIrq,
  input  logic               enWe,
  input  logic [NUM_SRC-1:0] enWdata,
  output logic [NUM_SRC-1:0] enState,
  input  logic               swWe,
  input  logic [VEC_W-1:0]   swWrVec,
  input  logic               swWrEn,
  output logic               swEnState,
  output logic               swEndIrq,
  output logic               xferStart,
  output logic [VEC_W-1:0]   xferVec,
  output logic               xferSw,
  input  logic               xferDone,
  input  logic               xferDoneLast,
  input  logic               xferDoneSel,
  input  logic               xferDoneCntEnd
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  rtrStb_t stb;
  logic    reqAny;

  dma_act_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqAny       (reqAny),
    .xferDone     (xferDone),
    .xferDoneLast (xferDoneLast),
    .stb          (stb),
    .xferStart    (xferStart)
  );

  dma_act_dp #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .SRC_W(SRC_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .srcFlag        (srcFlag),
    .enWe           (enWe),
    .enWdata        (enWdata),
    .swWe           (swWe),
    .swWrVec        (swWrVec),
    .swWrEn         (swWrEn),
    .xferDoneSel    (xferDoneSel),
    .xferDoneCntEnd (xferDoneCntEnd),
    .stb            (stb),
    .reqAny         (reqAny),
    .srcClr         (srcClr),
    .cpuIrq         (cpuIrq),
    .swEndIrq       (swEndIrq),
    .enState        (enState),
    .swEnState      (swEnState),
    .xferVec        (xferVec),
    .xferSw         (xferSw)
  );

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart) else $error("back-to-back starts"); // R2

endmodule

// File: tb/dma_act_router_tb.sv
module dma_act_router_tb_top;

  localparam int N = 8;
  localparam int VW = 6;

  typedef struct packed {
    logic [7:0] setMask;
    logic [7:0] enMask;
    logic       sel;
    logic       cnt;
    logic [5:0] expVec;
    logic [7:0] expClr;
    logic [7:0] expEn;
    logic [7:0] expIrq;
  } vecRow_t;

  localparam int ROWS = 6;
  localparam vecRow_t TABLE [ROWS] = '{
    '{8'h04, 8'h04, 1'b0, 1'b0, 6'd2, 8'h04, 8'h04, 8'h00},  // R5 plain end
    '{8'h10, 8'h10, 1'b1, 1'b0, 6'd4, 8'h00, 8'h00, 8'h10},  // R6 select bit
    '{8'h01, 8'h01, 1'b0, 1'b1, 6'd0, 8'h00, 8'h00, 8'h01},  // R6 count ended
    '{8'h28, 8'h28, 1'b0, 1'b0, 6'd3, 8'h08, 8'h28, 8'h00},  // R3 lowest wins
    '{8'hC0, 8'h80, 1'b0, 1'b0, 6'd7, 8'h80, 8'h80, 8'h40},  // R1 unrouted flag to CPU
    '{8'h06, 8'h06, 1'b1, 1'b1, 6'd1, 8'h00, 8'h04, 8'h02}   // R3/R6 both bits
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  flagReg = '0;
  logic [N-1:0]  flagSet = '0;
  logic [N-1:0]  flagDrop = '0;
  logic [N-1:0]  srcClr, cpuIrq, enState;
  logic          enWe = 1'b0;
  logic [N-1:0]  enWdata = '0;
  logic          swWe = 1'b0;
  logic [VW-1:0] swWrVec = '0;
  logic          swWrEn = 1'b0;
  logic          swEnState, swEndIrq;
  logic          xferStart, xferSw;
  logic [VW-1:0] xferVec;
  logic          xferDone = 1'b0, xferDoneLast = 1'b0, xferDoneSel = 1'b0, xferDoneCntEnd = 1'b0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Peripheral model: flags set by stimulus, cleared by the router's pulse
  always @(posedge clk) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg | flagSet) & ~flagDrop & ~srcClr;
  end

  dma_act_router #(.NUM_SRC(N), .VEC_W(VW)) dut_i (
    .clk(clk), .rstN(rstN), .srcFlag(flagReg), .srcClr(srcClr), .cpuIrq(cpuIrq),
    .enWe(enWe), .enWdata(enWdata), .enState(enState),
    .swWe(swWe), .swWrVec(swWrVec), .swWrEn(swWrEn),
    .swEnState(swEnState), .swEndIrq(swEndIrq),
    .xferStart(xferStart), .xferVec(xferVec), .xferSw(xferSw),
    .xferDone(xferDone), .xferDoneLast(xferDoneLast),
    .xferDoneSel(xferDoneSel), .xferDoneCntEnd(xferDoneCntEnd)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeEn(input logic [N-1:0] m);
    enWe = 1'b1; enWdata = m; tick(); enWe = 1'b0;
  endtask

  task automatic raise(input logic [N-1:0] m);
    flagSet = m; tick(); flagSet = '0;
  endtask

  task automatic drop(input logic [N-1:0] m);
    flagDrop = m; tick(); flagDrop = '0;
  endtask

  task automatic swWrite(input logic [VW-1:0] v, input logic e);
    swWe = 1'b1; swWrVec = v; swWrEn = e; tick(); swWe = 1'b0;
  endtask

  task automatic waitStart(output logic ok, output logic [VW-1:0] v, output logic sw);
    ok = 1'b0; v = '0; sw = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (xferStart) begin
        ok = 1'b1; v = xferVec; sw = xferSw;
        break;
      end
      tick();
    end
  endtask

  task automatic done(input logic sel, input logic cnt, input logic last);
    xferDone = 1'b1; xferDoneSel = sel; xferDoneCntEnd = cnt; xferDoneLast = last;
    tick();
    xferDone = 1'b0; xferDoneSel = 1'b0; xferDoneCntEnd = 1'b0; xferDoneLast = 1'b0;
  endtask

  task automatic quietCycles(input string req, input int n);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (xferStart) seen = 1'b1;
      tick();
    end
    check(req, seen, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic ok, sw;
    logic [VW-1:0] v;

    // R10 reset state
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R10 enState", enState, 0);
    check("R10 swEnState", swEnState, 0);
    check("R10 swEndIrq", swEndIrq, 0);
    check("R10 xferStart", xferStart, 0);
    check("R10 srcClr", srcClr, 0);

    // R1: unrouted flag goes to CPU and starts nothing
    raise(8'h02);
    check("R1 cpuIrq unrouted", cpuIrq, 8'h02);
    quietCycles("R1 no start when unrouted", 4);
    writeEn(8'h02);
    check("R1 cpuIrq drops when routed", cpuIrq, 8'h00);
    waitStart(ok, v, sw);
    check("R2 start seen", ok, 1'b1);
    check("R2 vector", v, 1);
    check("R2 hardware marker", sw, 0);
    done(1'b0, 1'b0, 1'b1);
    check("R5 clear pulse", srcClr, 8'h02);
    writeEn(8'h00);
    check("R5 clear one cycle", srcClr, 8'h00);
    drop(8'hFF);
    quietCycles("R2 no extra start", 3);

    // Table walk
    for (int r = 0; r < ROWS; r++) begin
      writeEn(TABLE[r].enMask);
      raise(TABLE[r].setMask);
      waitStart(ok, v, sw);
      check($sformatf("R2 row%0d start", r), ok, 1'b1);
      check($sformatf("R3 row%0d vector", r), v, TABLE[r].expVec);
      check($sformatf("R2 row%0d hw marker", r), sw, 0);
      done(TABLE[r].sel, TABLE[r].cnt, 1'b1);
      check($sformatf("R5 row%0d srcClr", r), srcClr, TABLE[r].expClr);
      check($sformatf("R6 row%0d enState", r), enState, TABLE[r].expEn);
      check($sformatf("R1 row%0d cpuIrq", r), cpuIrq, TABLE[r].expIrq);
      writeEn(8'h00);
      drop(8'hFF);
      quietCycles($sformatf("R2 row%0d idle after", r), 3);
    end

    // R4/R7 software start, plain end
    swWrite(6'd42, 1'b1);
    check("R4 swEnState set", swEnState, 1);
    waitStart(ok, v, sw);
    check("R4 sw start", ok, 1'b1);
    check("R4 sw vector", v, 42);
    check("R4 sw marker", sw, 1);
    done(1'b0, 1'b0, 1'b1);
    check("R7 swEn cleared", swEnState, 0);
    check("R7 no swEndIrq", swEndIrq, 0);
    quietCycles("R7 no restart", 4);

    // R8 software start, interrupting end
    swWrite(6'd5, 1'b1);
    waitStart(ok, v, sw);
    check("R8 sw start", ok, 1'b1);
    check("R8 sw vector", v, 5);
    done(1'b1, 1'b0, 1'b1);
    check("R8 swEn kept", swEnState, 1);
    check("R8 swEndIrq raised", swEndIrq, 1);
    quietCycles("R8 no restart while held", 5);
    check("R8 swEndIrq held", swEndIrq, 1);
    swWrite(6'd5, 1'b0);
    check("R8 swEndIrq released", swEndIrq, 0);

    // R3 hardware beats a simultaneous software request
    writeEn(8'h40);
    swWe = 1'b1; swWrVec = 6'd9; swWrEn = 1'b1; flagSet = 8'h40;
    tick();
    swWe = 1'b0; flagSet = '0;
    waitStart(ok, v, sw);
    check("R3 hw first vector", v, 6);
    check("R3 hw first marker", sw, 0);
    done(1'b0, 1'b0, 1'b1);
    check("R3 hw flag cleared", srcClr, 8'h40);
    waitStart(ok, v, sw);
    check("R3 sw second start", ok, 1'b1);
    check("R3 sw second vector", v, 9);
    check("R3 sw second marker", sw, 1);
    done(1'b0, 1'b0, 1'b1);
    check("R7 swEn cleared after second", swEnState, 0);
    writeEn(8'h00);
    quietCycles("R3 idle after pair", 3);

    // R9 chain: mid link does nothing, last link applies rules
    writeEn(8'h02);
    raise(8'h02);
    waitStart(ok, v, sw);
    check("R9 chain start", v, 1);
    done(1'b0, 1'b0, 1'b0);
    check("R9 no clear on link", srcClr, 8'h00);
    check("R9 enable kept on link", enState, 8'h02);
    quietCycles("R9 no restart on link", 4);
    check("R9 no clear later", flagReg, 8'h02);
    done(1'b0, 1'b1, 1'b1);
    check("R9 last link disables", enState, 8'h00);
    check("R6 chain end irq", cpuIrq, 8'h02);
    check("R6 chain end no clear", srcClr, 8'h00);
    drop(8'hFF);

    summary();
    $finish;
  end

endmodule